// File: doc/BRIEF.md
# Secret key holder with inactivity wipe

This block keeps a secret key of up to eight 32-bit words for a neighbouring cipher engine and erases it by itself once the key has gone unused for a programmable number of clock cycles. Software writes the key words and the timeout length, and reads a status word, all over a simple register port of chip select, write enable, address and data. Reads complete one cycle after the strobe. A control bit lets software force an immediate erase, and two other control bits produce single-cycle init and next strobes for the engine.

The engine reports back through three inputs: busy, init-done and operation-done. The expiry countdown runs only while a key is loaded and the engine is idle. It freezes while the engine is busy and reloads from the timeout register each time an initialisation or an operation completes. A read of the status register also reloads it, so software that polls status keeps the key alive. An erase requested while the engine is busy is held back until busy drops, and then happens in that very cycle.

A small state machine tracks the key: EMPTY (no key), COUNT (key loaded, counting down), HOLD (key loaded, engine busy, count frozen) and WIPE (one cycle after an erase). The transitions are EMPTY to COUNT on init-done; COUNT to HOLD when busy is seen; HOLD to COUNT when busy drops; any state to WIPE when an erase takes effect; and WIPE to EMPTY on the following cycle.

Top module: `key_store_top`

## Requirements
- R1: After reset the key output is all zero, key_loaded is 0 and the timeout register (address 0x0b) reads 0x0400_0000.
- R2: A write to address 0x10+k (k = 0..7) stores the data in key word k, which drives key_out[32k+31:32k].
- R3: An init-done pulse moves the block from EMPTY to COUNT, raises key_loaded at that clock edge and loads the counter from the timeout register.
- R4: With the engine idle, if the counter is loaded with T at edge E, the key is cleared to zero and key_loaded drops at edge E+T+1.
- R5: While eng_busy is high the block sits in HOLD and the counter does not change. The edge at which busy is first seen low returns the block to COUNT without decrementing.
- R6: An operation-done pulse reloads the counter from the timeout register.
- R7: A status read (address 0x09) reloads the counter. The returned word has ready in bit 0, the engine valid input in bit 1 and key-loaded in bit 2, with all other bits zero.
- R8: Writing the control register (0x08) with bit 2 set while the engine is idle clears the key and key_loaded at that edge. Bits 0 and 1 raise init_pulse and next_pulse for exactly the one cycle after the write.
- R9: An erase written while eng_busy is high is deferred. It takes effect at the first edge where busy is low, and it beats a key write landing at that same edge.
- R10: Read data and rd_err appear in the cycle after the read strobe. Unmapped addresses read zero with rd_err=1. The control register and the write-only key addresses read zero with rd_err=0.
- R11: For the one cycle in WIPE, the status word reports ready=0 and key-loaded=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after the strobe |
| rd_err | output | 1 | Read of an unmapped address, same cycle as rdata |
| eng_busy | input | 1 | Engine is running an operation |
| eng_valid | input | 1 | Engine result valid, reported in status |
| eng_init_done | input | 1 | Pulse: key initialisation finished |
| eng_op_done | input | 1 | Pulse: wrap or unwrap operation finished |
| key_out | output | 256 | Key words to the engine, word k at bits 32k+31:32k |
| key_loaded | output | 1 | A key is loaded and not yet wiped |
| init_pulse | output | 1 | Single-cycle init strobe to the engine |
| next_pulse | output | 1 | Single-cycle next strobe to the engine |

## Verification
The hardest case to reach is a deferred erase that is released in the same cycle as a competing key write. The stimulus holds eng_busy high, requests the erase through the control register and confirms that the key survives while busy stays high. It then drops busy and writes key word 0 in one and the same cycle, and expects all key words to come out zero. The freeze and reload behaviours are shown by exact edge counts: the bench counts the edges from the last reload to the fall of key_loaded, around a long busy window, an operation-done pulse and a status poll.

// File: rtl/kz_pkg.sv
package kz_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2,
        ST_WIPE  = 2'd3
    } kz_state_e;

    localparam logic [7:0]  KZ_ADDR_CTRL = 8'h08;
    localparam logic [7:0]  KZ_ADDR_STAT = 8'h09;
    localparam logic [7:0]  KZ_ADDR_TMO  = 8'h0b;
    localparam logic [7:0]  KZ_KEY_BASE  = 8'h10;

    localparam int KZ_BIT_INIT = 0;
    localparam int KZ_BIT_NEXT = 1;
    localparam int KZ_BIT_WIPE = 2;

    localparam logic [31:0] KZ_TMO_RESET = 32'h0400_0000;
endpackage

// File: rtl/kz_keyregs.sv
module kz_keyregs #(
    parameter int KEY_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(KEY_WORDS),
    localparam int KEY_W    = KEY_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clear,
    output logic [KEY_W-1:0]  key_flat
);
    for (genvar k = 0; k < KEY_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (clear) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                word_q <= wr_data;
            end
        end

        assign key_flat[k*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/kz_timer.sv
module kz_timer #(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] RESET_VAL = CNT_W'(32'h0400_0000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             dec_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RESET_VAL;
        end else if (reload) begin
            cnt_q <= load_val;
        end else if (dec_en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/kz_fsm.sv
module kz_fsm
    import kz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      init_done,
    input  logic      busy,
    input  logic      sw_wipe,
    input  logic      cnt_zero,
    output kz_state_e state_q,
    output logic      wipe_now,
    output logic      dec_en,
    output logic      loaded
);
    kz_state_e state_d;
    logic      pend_q;
    logic      pend_d;
    logic      expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // next state and outputs
    always_comb begin
        expire   = (state_q == ST_COUNT) && cnt_zero && !busy;
        wipe_now = (sw_wipe || pend_q || expire) && !busy;
        dec_en   = 1'b0;
        loaded   = 1'b0;
        state_d  = state_q;

        if (wipe_now) begin
            pend_d = 1'b0;
        end else if (sw_wipe) begin
            pend_d = 1'b1;
        end else begin
            pend_d = pend_q;
        end

        unique case (state_q)
            ST_EMPTY: begin
                if (init_done) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                loaded = 1'b1;
                if (busy) state_d = ST_HOLD;
                else      dec_en  = 1'b1;
            end
            ST_HOLD: begin
                loaded = 1'b1;
                if (!busy) state_d = ST_COUNT;
            end
            ST_WIPE: begin
                state_d = ST_EMPTY;
            end
        endcase

        if (wipe_now) state_d = ST_WIPE;
    end
endmodule

// File: rtl/key_store_top.sv
module key_store_top
    import kz_pkg::*;
#(
    parameter int KEY_WORDS = 8,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = $clog2(KEY_WORDS),
    localparam int KEY_W    = KEY_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_err,
    input  logic              eng_busy,
    input  logic              eng_valid,
    input  logic              eng_init_done,
    input  logic              eng_op_done,
    output logic [KEY_W-1:0]  key_out,
    output logic              key_loaded,
    output logic              init_pulse,
    output logic              next_pulse
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(KZ_ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(KZ_ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(KZ_ADDR_TMO);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KZ_KEY_BASE);

    logic              wr_acc;
    logic              rd_acc;
    logic              key_hit;
    logic              sw_wipe;
    logic              stat_rd;
    logic              wipe_now;
    logic              dec_en;
    logic              cnt_zero;
    logic              ready;
    logic [WORD_W-1:0] tmo_q;
    logic [WORD_W-1:0] cnt_q;
    kz_state_e         state_q;

    assign wr_acc  = cs && we;
    assign rd_acc  = cs && !we;
    assign key_hit = (addr[ADDR_W-1:IDX_W] == A_KEY[ADDR_W-1:IDX_W]);
    assign sw_wipe = wr_acc && (addr == A_CTRL) && wdata[KZ_BIT_WIPE];
    assign stat_rd = rd_acc && (addr == A_STAT);
    assign ready   = !eng_busy && (state_q != ST_WIPE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_q      <= WORD_W'(KZ_TMO_RESET);
            init_pulse <= 1'b0;
            next_pulse <= 1'b0;
        end else begin
            if (wr_acc && (addr == A_TMO)) tmo_q <= wdata;
            init_pulse <= wr_acc && (addr == A_CTRL) && wdata[KZ_BIT_INIT];
            next_pulse <= wr_acc && (addr == A_CTRL) && wdata[KZ_BIT_NEXT];
        end
    end

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_err <= 1'b0;
        end else if (rd_acc) begin
            rd_err <= 1'b0;
            if (addr == A_STAT) begin
                rdata <= {{(WORD_W-3){1'b0}}, key_loaded, eng_valid, ready};
            end else if (addr == A_TMO) begin
                rdata <= tmo_q;
            end else if ((addr == A_CTRL) || key_hit) begin
                rdata <= '0;
            end else begin
                rdata  <= '0;
                rd_err <= 1'b1;
            end
        end else begin
            rdata  <= '0;
            rd_err <= 1'b0;
        end
    end

    kz_keyregs #(
        .KEY_WORDS (KEY_WORDS),
        .WORD_W    (WORD_W)
    ) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_acc && key_hit),
        .wr_idx   (addr[IDX_W-1:0]),
        .wr_data  (wdata),
        .clear    (wipe_now),
        .key_flat (key_out)
    );

    kz_timer #(
        .CNT_W     (WORD_W),
        .RESET_VAL (WORD_W'(KZ_TMO_RESET))
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (eng_init_done || eng_op_done || stat_rd),
        .dec_en   (dec_en),
        .load_val (tmo_q),
        .cnt_q    (cnt_q),
        .cnt_zero (cnt_zero)
    );

    kz_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (eng_init_done),
        .busy      (eng_busy),
        .sw_wipe   (sw_wipe),
        .cnt_zero  (cnt_zero),
        .state_q   (state_q),
        .wipe_now  (wipe_now),
        .dec_en    (dec_en),
        .loaded    (key_loaded)
    );
endmodule

// File: rtl/kz_checker.sv
module kz_checker #(
    parameter int KEY_W  = 256,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic              wd_init,
    input logic              wd_wipe,
    input logic              eng_busy,
    input logic              eng_init_done,
    input logic [KEY_W-1:0]  key_out,
    input logic              key_loaded,
    input logic              init_pulse,
    input logic [WORD_W-1:0] rdata,
    input logic              rd_err,
    input logic [WORD_W-1:0] cnt,
    input logic [WORD_W-1:0] tmo
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(8'h09);

    assert_loaded_from_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_loaded) |-> $past(eng_init_done));

    assert_wipe_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_loaded) |-> (key_out == '0));

    assert_no_wipe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_loaded) |-> !$past(eng_busy));

    assert_poll_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs && !we && (addr == STAT_A)) |-> (cnt == $past(tmo)));

    assert_sw_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs && we && (addr == CTRL_A) && wd_wipe && !eng_busy) |-> (key_out == '0));

    assert_init_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |-> $past(cs && we && (addr == CTRL_A) && wd_init));

    assert_err_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rdata == '0));
endmodule

bind key_store_top kz_checker #(
    .KEY_W  (KEY_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs            (cs),
    .we            (we),
    .addr          (addr),
    .wd_init       (wdata[0]),
    .wd_wipe       (wdata[2]),
    .eng_busy      (eng_busy),
    .eng_init_done (eng_init_done),
    .key_out       (key_out),
    .key_loaded    (key_loaded),
    .init_pulse    (init_pulse),
    .rdata         (rdata),
    .rd_err        (rd_err),
    .cnt           (cnt_q),
    .tmo           (tmo_q)
);

// File: tb/key_store_top_tb_top.sv
`timescale 1ns/1ps
module key_store_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0;
    logic         we = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         rd_err;
    logic         eng_busy = 1'b0;
    logic         eng_valid = 1'b0;
    logic         eng_init_done = 1'b0;
    logic         eng_op_done = 1'b0;
    logic [255:0] key_out;
    logic         key_loaded;
    logic         init_pulse;
    logic         next_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    key_store_top dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rd_err(rd_err), .eng_busy(eng_busy), .eng_valid(eng_valid),
        .eng_init_done(eng_init_done), .eng_op_done(eng_op_done), .key_out(key_out),
        .key_loaded(key_loaded), .init_pulse(init_pulse), .next_pulse(next_pulse)
    );

    // {we, addr, wdata, expected rdata, expected rd_err}
    localparam logic [73:0] BUS_TBL [15] = '{
        {1'b0, 8'h0b, 32'h0, 32'h0400_0000, 1'b0},
        {1'b0, 8'h09, 32'h0, 32'h0000_0001, 1'b0},
        {1'b1, 8'h0b, 32'h5, 32'h0, 1'b0},
        {1'b0, 8'h0b, 32'h0, 32'h0000_0005, 1'b0},
        {1'b0, 8'h05, 32'h0, 32'h0, 1'b1},
        {1'b0, 8'h0a, 32'h0, 32'h0, 1'b1},
        {1'b0, 8'h12, 32'h0, 32'h0, 1'b0},
        {1'b1, 8'h17, 32'hAB12_C007, 32'h0, 1'b0},
        {1'b1, 8'h13, 32'hAB12_C003, 32'h0, 1'b0},
        {1'b1, 8'h10, 32'hAB12_C000, 32'h0, 1'b0},
        {1'b1, 8'h15, 32'hAB12_C005, 32'h0, 1'b0},
        {1'b1, 8'h11, 32'hAB12_C001, 32'h0, 1'b0},
        {1'b1, 8'h16, 32'hAB12_C006, 32'h0, 1'b0},
        {1'b1, 8'h12, 32'hAB12_C002, 32'h0, 1'b0},
        {1'b1, 8'h14, 32'hAB12_C004, 32'h0, 1'b0}
    };

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all bus tasks are entered at a falling edge and return at the next one
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a);
        cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic pulse_init();
        eng_init_done = 1'b1;
        @(negedge clk);
        eng_init_done = 1'b0;
    endtask

    task automatic load_key();
        for (int k = 0; k < 8; k++) bus_wr(8'h10 + 8'(k), 32'h5A5A_0100 + 32'(k));
        pulse_init();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 key_out", key_out, '0);
        chk("R1 key_loaded", {255'b0, key_loaded}, '0);

        // table walk: R1 timeout reset, R7 status, R10 read map, R2 key writes
        for (int i = 0; i < 15; i++) begin
            logic [73:0] e;
            e = BUS_TBL[i];
            if (e[73]) begin
                bus_wr(e[72:65], e[64:33]);
            end else begin
                bus_rd(e[72:65]);
                chk((i == 0) ? "R1 rdata" : "R10 rdata", {224'b0, rdata}, {224'b0, e[32:1]});
                chk("R10 rd_err", {255'b0, rd_err}, {255'b0, e[0]});
            end
        end
        for (int w = 0; w < 8; w++)
            chk("R2 key word", {224'b0, key_out[w*32 +: 32]}, {224'b0, 32'hAB12_C000 + 32'(w)});

        // R3 init loads key, R4 expiry at E0+T+1 with T=5
        pulse_init();
        chk("R3 loaded", {255'b0, key_loaded}, 256'd1);
        repeat (5) @(negedge clk);
        chk("R4 still loaded", {255'b0, key_loaded}, 256'd1);
        @(negedge clk);
        chk("R4 expired", {255'b0, key_loaded}, '0);
        chk("R4 key cleared", key_out, '0);
        // R11 status during WIPE cycle
        bus_rd(8'h09);
        chk("R11 status in wipe", {224'b0, rdata}, '0);

        // R5 busy freezes count
        load_key();
        repeat (2) @(negedge clk);
        eng_busy = 1'b1;
        repeat (20) @(negedge clk);
        chk("R5 frozen", {255'b0, key_loaded}, 256'd1);
        eng_busy = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 resumed", {255'b0, key_loaded}, 256'd1);
        @(negedge clk);
        chk("R5 expiry after resume", {255'b0, key_loaded}, '0);

        // R6 operation-done reloads
        load_key();
        repeat (3) @(negedge clk);
        eng_op_done = 1'b1;
        @(negedge clk);
        eng_op_done = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 reloaded", {255'b0, key_loaded}, 256'd1);
        @(negedge clk);
        chk("R6 expiry", {255'b0, key_loaded}, '0);

        // R7 status poll reloads and reports bits
        load_key();
        eng_valid = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(8'h09);
        chk("R7 status word", {224'b0, rdata}, 256'd7);
        eng_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 kept alive", {255'b0, key_loaded}, 256'd1);
        @(negedge clk);
        chk("R7 expiry", {255'b0, key_loaded}, '0);

        // R8 strobes and software wipe
        load_key();
        bus_wr(8'h08, 32'h3);
        chk("R8 init strobe", {255'b0, init_pulse}, 256'd1);
        chk("R8 next strobe", {255'b0, next_pulse}, 256'd1);
        chk("R8 key kept", {255'b0, key_loaded}, 256'd1);
        @(negedge clk);
        chk("R8 strobes single", {254'b0, init_pulse, next_pulse}, '0);
        bus_wr(8'h08, 32'h4);
        chk("R8 wipe key", key_out, '0);
        chk("R8 wipe loaded", {255'b0, key_loaded}, '0);
        chk("R8 no init strobe", {255'b0, init_pulse}, '0);

        // R9 deferred wipe beats key write
        load_key();
        eng_busy = 1'b1;
        @(negedge clk);
        bus_wr(8'h08, 32'h4);
        repeat (3) @(negedge clk);
        chk("R9 deferred loaded", {255'b0, key_loaded}, 256'd1);
        chk("R9 deferred key", {224'b0, key_out[31:0]}, 256'h5A5A_0100);
        eng_busy = 1'b0;
        bus_wr(8'h10, 32'hFFFF_FFFF);
        chk("R9 wipe wins", key_out, '0);
        chk("R9 loaded cleared", {255'b0, key_loaded}, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule